// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs external code-fetch and data-move cycles for an 8-bit core. Two ports carry them: a low port that is shared by the low address byte and the data, and a high port that carries the upper address byte. The core offers one request at a time. A request is one of three things: a code fetch, a data read or write through a 16-bit pointer, or a data read or write through an 8-bit indirect register. Once the controller accepts a request, it runs a fixed six-clock bus cycle. A one-clock address-latch pulse comes first, while the low port shows the low address byte. A three-clock strobe follows, during which the low port either carries the write data or is released for read data.

Fetches do not always reach the bus. An external-access input and a code limit parameter decide whether each fetch is served on-chip or off-chip. When the input is low, every fetch goes off-chip. When it is high, fetches at or below the limit stay on-chip and the controller answers them with a one-clock internal-hit pulse. Fetches above the limit roll over to the bus. In 8-bit mode the high port keeps the value of the core's port latch, so software can use it as a page register. At the start of every bus cycle, the controller raises a request to force the low-port latch to all ones. A new request can be accepted in the last clock of a running cycle, so back-to-back accesses give one address-latch pulse every six clocks.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, ale is 0, psen_n, rd_n and wr_n are 1, lo_oe is 0, req_ready is 1 and done is 0.
- R2: In the clock after an accepted bus request (phase 0), ale is 1 for exactly one clock and lo_out drives the low address byte with lo_oe=1. In phase 1, ale is 0 and the low address byte is still driven.
- R3: Strobes are active low and low only in phases 2, 3 and 4. None is ever low while ale is 1, and at most one is low at a time.
- R4: For a fetch (kind 0) or a 16-bit-pointer access (kind 1 read, kind 2 write), hi_out equals req_addr[15:8] in all six phases.
- R5: For an 8-bit-register access (kind 3 read, kind 4 write), hi_out equals hi_latch in all six phases, and lo_out carries req_addr[7:0] as the address.
- R6: For writes, lo_out drives req_wdata with lo_oe=1 from phase 2 through phase 5, which holds the data past the rising edge of wr_n. For reads and fetches, lo_oe is 0 from phase 2 on.
- R7: Read data is taken from lo_in at the last strobe-low clock (phase 4). It appears on rdata while done is 1 in phase 5.
- R8: lo_fill, the request to set the low-port latch to FFH, is 1 in phase 0 of every bus cycle and 0 otherwise.
- R9: A fetch goes to the bus when ext_code_en is 0, or when req_addr is above CODE_TOP (default 1FFFH). Otherwise the controller starts no bus cycle, and int_fetch is 1 for the one clock after acceptance.
- R10: Fetches strobe psen_n, reads strobe rd_n and writes strobe wr_n. Kind codes 5 to 7 start nothing.
- R11: req_ready is 0 in phases 0 to 4 and 1 in phase 5. A request accepted in phase 5 starts its phase 0 on the next clock, so ale rises every six clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core offers a request |
| req_kind | input | 3 | 0 fetch, 1 read16, 2 write16, 3 read8, 4 write8 |
| req_addr | input | 16 | Program counter, pointer, or indirect register in the low byte |
| req_wdata | input | 8 | Write data |
| ext_code_en | input | 1 | 1: fetches up to CODE_TOP stay on-chip |
| hi_latch | input | 8 | Core's high-port latch value |
| req_ready | output | 1 | Request is accepted this clock if valid |
| done | output | 1 | Last phase of a bus cycle, rdata valid |
| rdata | output | 8 | Captured read data |
| int_fetch | output | 1 | Fetch served on-chip |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port drive enable |
| lo_in | input | 8 | Low port input |
| hi_out | output | 8 | High port value |
| lo_fill | output | 1 | Force low-port latch to FFH |

## Verification
Four rules are checked on every clock: strobes stay clear of the address pulse, only one strobe is ever low, the address is held after ale falls, and write data is held past the wr_n rising edge. Also checked every clock: the high port stays steady during 16-bit cycles, it follows the latch in 8-bit mode, and an internal fetch stays off the bus. Only the bench's scenarios can show the rest: the exact phase of each strobe, the captured read value, the code-limit boundary at 1FFFH/2000H, the pulse period of back-to-back cycles, and the idle behaviour after an unused kind code.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    XK_FETCH = 3'd0,
    XK_RD16  = 3'd1,
    XK_WR16  = 3'd2,
    XK_RD8   = 3'd3,
    XK_WR8   = 3'd4
  } xkind_e;

  function automatic logic kind_known(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_write(input logic [2:0] k);
    return (k == XK_WR16) || (k == XK_WR8);
  endfunction

  function automatic logic kind_fetch(input logic [2:0] k);
    return k == XK_FETCH;
  endfunction

  function automatic logic kind_short(input logic [2:0] k);
    return (k == XK_RD8) || (k == XK_WR8);
  endfunction

  // A fetch leaves the chip when internal code is disabled or the PC passes the top.
  function automatic logic fetch_off_chip(input logic ext_en, input logic [15:0] pc,
                                          input logic [15:0] top);
    return !ext_en || (pc > top);
  endfunction
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int PHASES = 6,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [PW-1:0] phase,
  output logic          last
);
  assign last = active && (phase == PW'(PHASES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (start) begin
      active <= 1'b1;
      phase  <= '0;
    end else if (last) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (active) begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/xbus_route.sv
module xbus_route #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CODE_TOP = 16'h1FFF
) (
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_code_en,
  output logic              go_bus,
  output logic              go_int
);
  import xbus_pkg::*;
  logic off;

  assign off    = fetch_off_chip(ext_code_en, 16'(addr), CODE_TOP);
  assign go_bus = kind_known(kind) && (!kind_fetch(kind) || off);
  assign go_int = kind_fetch(kind) && !off;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter int          PHASES   = 6,
  parameter logic [15:0] CODE_TOP = 16'h1FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ADDR_W/2-1:0] req_wdata,
  input  logic                ext_code_en,
  input  logic [ADDR_W/2-1:0] hi_latch,
  output logic                req_ready,
  output logic                done,
  output logic [ADDR_W/2-1:0] rdata,
  output logic                int_fetch,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic [ADDR_W/2-1:0] lo_out,
  output logic                lo_oe,
  input  logic [ADDR_W/2-1:0] lo_in,
  output logic [ADDR_W/2-1:0] hi_out,
  output logic                lo_fill
);
  import xbus_pkg::*;

  localparam int DW          = ADDR_W / 2;
  localparam int PW          = $clog2(PHASES);
  localparam int STROBE_FROM = 2;
  localparam int STROBE_TO   = PHASES - 2;

  logic          bus_active, last_phase, accept, go_bus, go_int, start;
  logic [PW-1:0] phase;
  logic [2:0]    cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          addr_window, data_window, strobe_window, short_mode, is_wr, is_fetch;
  logic          sample_now;

  xbus_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(bus_active), .phase(phase), .last(last_phase)
  );

  xbus_route #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) u_route (
    .kind(req_kind), .addr(req_addr), .ext_code_en(ext_code_en),
    .go_bus(go_bus), .go_int(go_int)
  );

  assign req_ready = !bus_active || last_phase;
  assign accept    = req_valid && req_ready;
  assign start     = accept && go_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind  <= 3'd0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      int_fetch <= 1'b0;
    end else begin
      int_fetch <= accept && go_int;
      if (start) begin
        cur_kind  <= req_kind;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
    end
  end

  // Phase windows of the bus cycle
  assign addr_window   = bus_active && (phase < PW'(STROBE_FROM));
  assign data_window   = bus_active && (phase >= PW'(STROBE_FROM));
  assign strobe_window = data_window && (phase <= PW'(STROBE_TO));
  assign sample_now    = strobe_window && (phase == PW'(STROBE_TO)) && !is_wr;
  assign short_mode    = kind_short(cur_kind);
  assign is_wr         = kind_write(cur_kind);
  assign is_fetch      = kind_fetch(cur_kind);

  assign ale     = bus_active && (phase == '0);
  assign lo_fill = ale;
  assign psen_n  = !(strobe_window && is_fetch);
  assign rd_n    = !(strobe_window && !is_fetch && !is_wr);
  assign wr_n    = !(strobe_window && is_wr);
  assign done    = last_phase;

  assign lo_oe  = addr_window || (data_window && is_wr);
  assign lo_out = addr_window ? cur_addr[DW-1:0]
                : ((data_window && is_wr) ? cur_wdata : {DW{1'b1}});
  assign hi_out = (bus_active && !short_mode) ? cur_addr[ADDR_W-1:DW] : hi_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (sample_now) rdata <= lo_in;
  end
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       lo_oe,
  input logic [7:0] lo_out,
  input logic [7:0] hi_out,
  input logic [7:0] hi_latch,
  input logic       lo_fill,
  input logic       int_fetch,
  input logic       bus_active,
  input logic       short_mode
);
  AST_STROBE_CLEAR_OF_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n, !rd_n, !wr_n})); // R3
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (lo_oe && $stable(lo_out))); // R2
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (lo_oe && $stable(lo_out))); // R6
  AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !ale && !short_mode) |-> $stable(hi_out)); // R4
  AST_SHORT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && short_mode) |-> (hi_out == hi_latch)); // R5
  AST_FILL_AT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_fill |-> (ale && lo_oe)); // R8
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    int_fetch |-> (psen_n && !ale)); // R9
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .lo_oe(lo_oe), .lo_out(lo_out), .hi_out(hi_out), .hi_latch(hi_latch),
  .lo_fill(lo_fill), .int_fetch(int_fetch), .bus_active(bus_active),
  .short_mode(short_mode)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, hi_latch = '0, lo_in, rdata, lo_out, hi_out;
  logic ext_code_en = 1'b1;
  logic req_ready, done, int_fetch, ale, psen_n, rd_n, wr_n, lo_oe, lo_fill;
  logic [7:0] lat_lo = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_code_en(ext_code_en),
    .hi_latch(hi_latch), .req_ready(req_ready), .done(done), .rdata(rdata),
    .int_fetch(int_fetch), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out), .lo_fill(lo_fill)
  );

  // External memory model: low address latched on the falling edge of ale
  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return (a[7:0] + 8'(a[15:8] * 8'd3)) ^ 8'h96;
  endfunction
  always @(negedge ale) lat_lo = lo_out;
  assign lo_in = (!rd_n || !psen_n) ? mem_of({hi_out, lat_lo}) : 8'hC3;

  function automatic logic bus_needed(input logic [2:0] k, input logic [15:0] a, input logic ea);
    if (k > 3'd4) return 1'b0;
    if (k != 3'd0) return 1'b1;
    return (ea == 1'b0) || (a >= 16'h2000);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic run_access(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] p2, input logic ea);
    logic wr, sh, fe;
    logic [7:0] hexp;
    logic [5:0] got, exp;
    wr = (k == 3'd2) || (k == 3'd4);
    sh = (k == 3'd3) || (k == 3'd4);
    fe = (k == 3'd0);
    hexp = sh ? p2 : a[15:8];
    req_kind = k; req_addr = a; req_wdata = wd; hi_latch = p2; ext_code_en = ea;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (k > 3'd4) begin
      for (int i = 0; i < 7; i++) begin
        chk(!ale && psen_n && rd_n && wr_n && !int_fetch, "R10 unused kind idle",
            {ale, psen_n, rd_n, wr_n, int_fetch}, 32'h0E);
        @(negedge clk);
      end
    end else if (!bus_needed(k, a, ea)) begin
      chk(int_fetch && !ale && psen_n, "R9 internal fetch", {int_fetch, ale, psen_n}, 32'h5);
      @(negedge clk);
      chk(!int_fetch && !ale, "R9 internal pulse width", {int_fetch, ale}, 32'h0);
    end else begin
      for (int ph = 0; ph < 6; ph++) begin
        logic st;
        st = (ph >= 2) && (ph <= 4);
        exp = {ph == 0, !(st && fe), !(st && !fe && !wr), !(st && wr),
               (ph < 2) || wr, ph == 0};
        got = {ale, psen_n, rd_n, wr_n, lo_oe, lo_fill};
        chk(got == exp, $sformatf("R2 R3 R8 R10 strobes ph%0d", ph), got, exp);
        if (ph < 2)
          chk(lo_out == a[7:0], $sformatf("R2 R5 address ph%0d", ph), lo_out, a[7:0]);
        else if (wr)
          chk(lo_out == wd, $sformatf("R6 write data ph%0d", ph), lo_out, wd);
        chk(hi_out == hexp, $sformatf("R4 R5 high port ph%0d", ph), hi_out, hexp);
        chk(req_ready == (ph == 5) && done == (ph == 5), $sformatf("R11 ready/done ph%0d", ph),
            {req_ready, done}, {ph == 5, ph == 5});
        if (ph == 5 && !wr)
          chk(rdata == mem_of({hexp, a[7:0]}), "R7 read data", rdata, mem_of({hexp, a[7:0]}));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1955));
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !lo_oe && !done, "R1 reset outputs",
        {ale, psen_n, rd_n, wr_n, lo_oe, done}, 32'h1C);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // Directed corner cases
    run_access(3'd0, 16'h1FFF, 8'h00, 8'h11, 1'b1); // R9 top of on-chip code
    run_access(3'd0, 16'h2000, 8'h00, 8'h11, 1'b1); // R9 rollover
    run_access(3'd0, 16'h0040, 8'h00, 8'h11, 1'b0); // R9 external only
    run_access(3'd1, 16'hA55A, 8'h00, 8'h22, 1'b1); // R4
    run_access(3'd2, 16'h3C81, 8'hE7, 8'h22, 1'b1); // R6
    run_access(3'd3, 16'hFF37, 8'h00, 8'h9D, 1'b1); // R5
    run_access(3'd4, 16'h0012, 8'h6B, 8'h40, 1'b1); // R5 R6
    run_access(3'd6, 16'h1234, 8'h00, 8'h00, 1'b0); // R10

    // Back-to-back: second request accepted in the last phase (R11)
    req_kind = 3'd1; req_addr = 16'h4321; hi_latch = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(req_ready && done, "R11 ready in last phase", {req_ready, done}, 32'h3);
    req_kind = 3'd2; req_addr = 16'h8765; req_wdata = 8'h5C; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ale && lo_out == 8'h65 && hi_out == 8'h87, "R11 ale after six clocks",
        {ale, lo_out, hi_out}, {1'b1, 8'h65, 8'h87});
    repeat (6) @(negedge clk);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] k;
      logic [15:0] a;
      k = 3'($urandom % 6);
      if (k == 3'd5) k = 3'd0;
      a = 16'($urandom);
      if (k == 3'd0 && ($urandom % 2) == 0) a = a & 16'h1FFF;
      run_access(k, a, 8'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule